// File: doc/BRIEF.md
# Dual-Issue Pipe Steering Dispatcher

This block sits between a two-wide issue stage and four execution pipes: complex integer, simple integer, load/store and floating point. Each cycle it looks at up to two instruction class tags, decides which pipe or pipes each one must enter, and grants the slot only when every register-access stage it needs is empty. Each pipe's register-access stage is a one-entry holding slot. An instruction sits in that slot until the pipe reports that its source operands are ready.

Plain integer work can go to either integer pipe. By default it goes to the simple-integer pipe when that pipe is free. Multiply, divide, branch, trap and special-register moves use only the complex-integer pipe. Reservation loads and conditional stores take the load/store and complex-integer stages in the same cycle, and they are accepted only from slot 0. A full synchronize takes the floating-point, load/store and complex-integer stages together. The two slots keep program order: slot 0 wins any contention, and slot 1 never moves unless slot 0 moves in the same cycle.

Top module: `pipe_steer`

## Requirements
- R1: After reset every holding slot is empty: `hold_busy` reads 0.
- R2: Class code 1 (complex-only) claims pipe bit 0 (complex integer). Code 2 (memory) claims bit 2 (load/store). Code 3 (float) claims bit 3 (floating point). Reserved codes 6 and 7 behave as code 1. Pipe bit 1 is the simple-integer pipe.
- R3: Class code 0 (plain integer) goes to the simple-integer pipe when its slot is empty. Otherwise it goes to the complex-integer pipe when that slot is empty. With both full, the instruction stalls.
- R4: Class code 4 (reservation/conditional) claims pipes 0 and 2 together and is granted only from slot 0. In slot 1 it is never granted.
- R5: Class code 5 (synchronize) claims pipes 0, 2 and 3 together and is granted only when all three are empty.
- R6: A slot is granted only if every holding slot it claims is empty. On the next clock edge those holding slots become busy.
- R7: A busy holding slot stays busy while its `pipe_rdy` bit is low. It becomes empty on the edge where that bit is high.
- R8: When both slots need the same pipe, slot 0 gets it and slot 1 stalls. The two claim masks never overlap.
- R9: Slot 1 is granted only in a cycle where slot 0 is also granted.
- R10: `s0_pipe` and `s1_pipe` are zero whenever the matching grant is low.
- R11: Two instructions that need disjoint, empty pipes are both granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s0_vld | input | 1 | Slot 0 holds an instruction |
| s0_kind | input | 3 | Slot 0 class code |
| s1_vld | input | 1 | Slot 1 holds an instruction |
| s1_kind | input | 3 | Slot 1 class code |
| pipe_rdy | input | 4 | Per-pipe operands-ready; drains that pipe's holding slot |
| s0_gnt | output | 1 | Slot 0 dispatched this cycle |
| s0_pipe | output | 4 | Pipes claimed by slot 0 (one bit per pipe) |
| s1_gnt | output | 1 | Slot 1 dispatched this cycle |
| s1_pipe | output | 4 | Pipes claimed by slot 1 |
| hold_busy | output | 4 | Occupancy of each pipe's holding slot |

## Verification
The assertions assume a synchronous reset at start-up and class codes with no unknown bits whenever a valid bit is high. They make no assumption about `pipe_rdy`, which may change in any cycle. The stimulus drives only defined 3-bit codes, including the two reserved ones. It changes inputs only at the falling edge, so the grant paths settle before they are sampled. Random `pipe_rdy` patterns hold slots busy for several cycles and also drain them at once, which exercises both sides of the holding rule.

// File: rtl/steer_pkg.sv
package steer_pkg;
   localparam int PIPE_N  = 4;
   localparam int KIND_W  = 3;
   localparam int P_CPLX  = 0;
   localparam int P_SIMP  = 1;
   localparam int P_MEM   = 2;
   localparam int P_FLT   = 3;

   typedef enum logic [KIND_W-1:0] {
      K_ALU  = 3'd0,
      K_CPLX = 3'd1,
      K_MEM  = 3'd2,
      K_FLT  = 3'd3,
      K_ATOM = 3'd4,
      K_SYNC = 3'd5,
      K_RSV6 = 3'd6,
      K_RSV7 = 3'd7
   } kind_e;
endpackage

// File: rtl/steer_pick.sv
module steer_pick
   import steer_pkg::*;
#(
   parameter bit PREFER_SIMPLE = 1'b1,
   parameter bit ALLOW_ATOM    = 1'b1
) (
   input  logic              vld,
   input  logic [KIND_W-1:0] kind,
   input  logic [PIPE_N-1:0] free,
   output logic              gnt,
   output logic [PIPE_N-1:0] claim
);
   logic [PIPE_N-1:0] alu_mask;
   logic [PIPE_N-1:0] need;
   logic              kind_ok;

   generate
      if (PREFER_SIMPLE) begin : g_pref_simple
         always_comb begin
            alu_mask = '0;
            if (free[P_SIMP]) alu_mask[P_SIMP] = 1'b1;
            else              alu_mask[P_CPLX] = 1'b1;
         end
      end else begin : g_pref_cplx
         always_comb begin
            alu_mask = '0;
            if (free[P_CPLX]) alu_mask[P_CPLX] = 1'b1;
            else              alu_mask[P_SIMP] = 1'b1;
         end
      end
   endgenerate

   always_comb begin
      need    = '0;
      kind_ok = 1'b1;
      case (kind_e'(kind))
         K_ALU:  need = alu_mask;
         K_MEM:  need[P_MEM] = 1'b1;
         K_FLT:  need[P_FLT] = 1'b1;
         K_ATOM: begin
            need[P_MEM]  = 1'b1;
            need[P_CPLX] = 1'b1;
            kind_ok      = ALLOW_ATOM;
         end
         K_SYNC: begin
            need[P_MEM]  = 1'b1;
            need[P_CPLX] = 1'b1;
            need[P_FLT]  = 1'b1;
         end
         default: need[P_CPLX] = 1'b1;
      endcase
   end

   assign gnt   = vld && kind_ok && ((need & ~free) == '0);
   assign claim = gnt ? need : '0;
endmodule

// File: rtl/hold_slot.sv
module hold_slot (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic rdy,
   output logic busy
);
   logic busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= take | (busy_q & ~rdy);
   end

   assign busy = busy_q;

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !busy_q);
   // R7
   hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && !rdy |=> busy_q);
   // R7
   hold_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q && rdy |=> !busy_q);
endmodule

// File: rtl/pipe_steer.sv
module pipe_steer
   import steer_pkg::*;
#(
   parameter bit PREFER_SIMPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s0_vld,
   input  logic [KIND_W-1:0] s0_kind,
   input  logic              s1_vld,
   input  logic [KIND_W-1:0] s1_kind,
   input  logic [PIPE_N-1:0] pipe_rdy,
   output logic              s0_gnt,
   output logic [PIPE_N-1:0] s0_pipe,
   output logic              s1_gnt,
   output logic [PIPE_N-1:0] s1_pipe,
   output logic [PIPE_N-1:0] hold_busy
);
   localparam int NP = PIPE_N;

   generate
      if (NP != 4) begin : g_bad_np
         $error("pipe_steer: exactly four pipes are supported");
      end
   endgenerate

   logic [NP-1:0] busy;
   logic [NP-1:0] free0, free1;
   logic [NP-1:0] claim0, claim1;
   logic          gnt0, gnt1;

   assign free0 = ~busy;
   assign free1 = ~busy & ~claim0;

   steer_pick #(.PREFER_SIMPLE(PREFER_SIMPLE), .ALLOW_ATOM(1'b1)) u_pick0 (
      .vld(s0_vld), .kind(s0_kind), .free(free0), .gnt(gnt0), .claim(claim0));

   steer_pick #(.PREFER_SIMPLE(PREFER_SIMPLE), .ALLOW_ATOM(1'b0)) u_pick1 (
      .vld(s1_vld & gnt0), .kind(s1_kind), .free(free1), .gnt(gnt1), .claim(claim1));

   for (genvar i = 0; i < NP; i++) begin : g_hold
      hold_slot u_hold (
         .clk(clk), .rst_n(rst_n), .take(claim0[i] | claim1[i]),
         .rdy(pipe_rdy[i]), .busy(busy[i]));
   end

   assign s0_gnt    = gnt0;
   assign s1_gnt    = gnt1;
   assign s0_pipe   = claim0;
   assign s1_pipe   = claim1;
   assign hold_busy = busy;

   // R9
   s1_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_gnt |-> s0_gnt);
   // R8
   claim_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s0_pipe & s1_pipe) == '0);
   // R4
   atom_slot1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_vld && s1_kind == K_ATOM |-> !s1_gnt);
   // R10
   idle_pipe0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s0_gnt |-> s0_pipe == '0);
   // R10
   idle_pipe1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !s1_gnt |-> s1_pipe == '0);
   // R6
   busy_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s0_gnt |=> (hold_busy & $past(s0_pipe)) == $past(s0_pipe));
endmodule

// File: tb/sim_pipe_steer.sv
module sim_pipe_steer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       s0_vld = 1'b0, s1_vld = 1'b0;
   logic [2:0] s0_kind = '0, s1_kind = '0;
   logic [3:0] pipe_rdy = '0;
   logic       s0_gnt, s1_gnt;
   logic [3:0] s0_pipe, s1_pipe, hold_busy;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [3:0] occ = '0;

   always #10 clk = ~clk;

   pipe_steer u0 (
      .clk(clk), .rst_n(rst_n), .s0_vld(s0_vld), .s0_kind(s0_kind),
      .s1_vld(s1_vld), .s1_kind(s1_kind), .pipe_rdy(pipe_rdy),
      .s0_gnt(s0_gnt), .s0_pipe(s0_pipe), .s1_gnt(s1_gnt),
      .s1_pipe(s1_pipe), .hold_busy(hold_busy));

   // expected claim for one class code against a free map
   function automatic void expect_slot(input bit v, input int k, input bit slot1,
                                       input logic [3:0] fr, output bit g,
                                       output logic [3:0] m);
      logic [3:0] need;
      if (k == 0)      need = fr[1] ? 4'b0010 : 4'b0001;
      else if (k == 2) need = 4'b0100;
      else if (k == 3) need = 4'b1000;
      else if (k == 4) need = 4'b0101;
      else if (k == 5) need = 4'b1101;
      else             need = 4'b0001;
      g = v && !(slot1 && k == 4) && ((need & ~fr) == 4'b0000);
      m = g ? need : 4'b0000;
   endfunction

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input string tag, input bit v0, input int k0,
                       input bit v1, input int k1, input logic [3:0] rdy);
      bit g0, g1;
      logic [3:0] m0, m1;
      @(negedge clk);
      s0_vld = v0; s0_kind = 3'(k0); s1_vld = v1; s1_kind = 3'(k1); pipe_rdy = rdy;
      #5;
      expect_slot(v0, k0, 1'b0, ~occ, g0, m0);
      expect_slot(v1 && g0, k1, 1'b1, ~occ & ~m0, g1, m1);
      cmp(tag, "hold_busy", int'(hold_busy), int'(occ));
      cmp(tag, "s0_gnt", int'(s0_gnt), int'(g0));
      cmp(tag, "s0_pipe", int'(s0_pipe), int'(m0));
      cmp(tag, "s1_gnt", int'(s1_gnt), int'(g1));
      cmp(tag, "s1_pipe", int'(s1_pipe), int'(m1));
      @(posedge clk);
      #1;
      occ = (occ & ~rdy) | m0 | m1;
   endtask

   task automatic drain();
      step("R7 drain", 1'b0, 0, 1'b0, 0, 4'b1111);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #5;
      cmp("R1 reset", "hold_busy", int'(hold_busy), 0);

      // R2 single-choice routing, R11 dual dispatch
      step("R2 cplx", 1'b1, 1, 1'b0, 0, 4'b0000);
      step("R11 mem+flt", 1'b1, 2, 1'b1, 3, 4'b0000);
      drain();
      step("R2 rsv6+rsv7", 1'b1, 6, 1'b1, 7, 4'b0000);
      drain();
      // R3 preference and fallback
      step("R3 alu pair", 1'b1, 0, 1'b1, 0, 4'b0000);
      step("R3 alu full", 1'b1, 0, 1'b0, 0, 4'b0000);
      step("R3 simp drains", 1'b1, 0, 1'b0, 0, 4'b0010);
      step("R3 alu to simp", 1'b1, 0, 1'b0, 0, 4'b0000);
      drain();
      // R4 reservation ops
      step("R4 atom slot1", 1'b1, 3, 1'b1, 4, 4'b0000);
      drain();
      step("R4 atom slot0", 1'b1, 4, 1'b1, 0, 4'b0000);
      drain();
      // R5 synchronize
      step("R5 flt busy", 1'b1, 3, 1'b0, 0, 4'b0000);
      step("R5 sync stall", 1'b1, 5, 1'b1, 0, 4'b0000);
      drain();
      step("R5 sync go", 1'b1, 5, 1'b1, 0, 4'b0000);
      // R7 hold until ready
      step("R7 wait", 1'b0, 0, 1'b0, 0, 4'b0000);
      step("R7 wait", 1'b0, 0, 1'b0, 0, 4'b0010);
      step("R7 partial", 1'b0, 0, 1'b0, 0, 4'b0001);
      drain();
      // R8 contention, R9 order, R6 busy blocks
      step("R8 same pipe", 1'b1, 1, 1'b1, 1, 4'b0000);
      step("R9 s0 stalls", 1'b1, 1, 1'b1, 3, 4'b0000);
      step("R9 no s0", 1'b0, 0, 1'b1, 3, 4'b0000);
      step("R6 mem busy", 1'b1, 2, 1'b0, 0, 4'b0001);
      drain();
      step("R10 idle", 1'b0, 5, 1'b0, 5, 4'b0000);

      for (int i = 0; i < 2000; i++) begin
         step("RND", 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)),
              1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)),
              4'($urandom_range(0, 15)));
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule